// File: doc/BRIEF.md
# Interrupt Controller Initialization Word Sequencer

This block sits at the register-write port of a programmable interrupt controller. It watches a one-cycle write strobe with an address bit and an 8-bit data byte. It recognises the word that opens an initialization sequence and then accepts the words that follow it. The sequence is two, three or four bytes long, and flags in the opening word set its length. Each word's mode fields are kept in registers that the rest of the controller reads.

The opening word also starts housekeeping in the neighbouring logic. The block gives a one-cycle pulse that clears the mask, re-arms edge detection, returns priority to its default order, leaves special mask mode and points status reads at the request register. When the last required word has arrived, a ready output goes high. From then on, writes that do not open a new sequence are handed on unchanged as operation commands for another block to decode.

Top module: `icw_seq_top`

## Requirements
- R1: After synchronous reset, `ready_o` is 0, every stored field is 0 and no pulse output is active.
- R2: A write with `wr_a0`=0 and `wr_data[4]`=1 is an opening word. It restarts the sequence from any state, and `ready_o` is 0 in the cycle after it.
- R3: After the opening word, the second word is always taken. The third word is taken only when the single bit (bit 1 of the opening word) is 0. The fourth word is taken only when the needs-fourth bit (bit 0) is 1. `ready_o` rises in the cycle after the last required word and not before.
- R4: The opening word stores the following fields. Bits 7..5 give vector address bits A7..A5 (`vec_lo_o`). Bit 3 is level trigger. Bit 2 is spacing, where 1 means spacing 4 and 0 means spacing 8. Bit 1 is single. Bit 0 is needs-fourth.
- R5: The second word is stored whole as the vector high byte, and it stays stable while no write occurs.
- R6: The third word, when it is taken, is stored whole as the slave register.
- R7: The fourth word stores the following fields. Bit 4 is special fully nested. Bit 3 is buffered. Bit 2 is master. Bit 1 is automatic end of interrupt. Bit 0 is processor mode, where 1 means two-pulse. Every opening word clears these fields, so they read 0 when no fourth word is requested.
- R8: In the cycle after an opening word, `mask_clr_o`, `edge_rst_o`, `prio_rst_o`, `smm_clr_o` and `rd_irr_o` are each 1 for exactly one cycle.
- R9: While ready, a write that is not an opening word gives `ocw_valid_o`=1 for one cycle in the next cycle, with its address bit and data on `ocw_a0_o`/`ocw_data_o`. Stored fields do not change.
- R10: While not ready, no write produces `ocw_valid_o`. Writes that are not opening words and arrive before any opening word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_a0 | input | 1 | Address bit of the write |
| wr_data | input | 8 | Write data |
| ready_o | output | 1 | Initialization complete |
| level_trig_o | output | 1 | Level-triggered inputs |
| spacing4_o | output | 1 | Vector spacing 4 (0: spacing 8) |
| single_o | output | 1 | Single-device configuration |
| need4_o | output | 1 | Fourth word requested |
| vec_lo_o | output | 3 | Vector address bits A7..A5 |
| vec_hi_o | output | 8 | Vector high byte |
| slave_o | output | 8 | Slave register |
| sfnm_o | output | 1 | Special fully nested mode |
| buffered_o | output | 1 | Buffered mode |
| master_o | output | 1 | Master in buffered mode |
| aeoi_o | output | 1 | Automatic end of interrupt |
| two_pulse_o | output | 1 | Two-pulse acknowledge mode |
| mask_clr_o | output | 1 | Pulse: clear mask register |
| edge_rst_o | output | 1 | Pulse: re-arm edge detection |
| prio_rst_o | output | 1 | Pulse: input 7 lowest priority |
| smm_clr_o | output | 1 | Pulse: leave special mask mode |
| rd_irr_o | output | 1 | Pulse: status reads select request register |
| ocw_valid_o | output | 1 | Operation command forwarded |
| ocw_a0_o | output | 1 | Forwarded address bit |
| ocw_data_o | output | 8 | Forwarded data |

## Verification
A wrong sequencer state shows at the ports one cycle after the write that should have moved it. In that case `ready_o` rises early or late, or a data byte lands in the wrong field register, so the next field read shows another word's byte. A missed restart shows in the same cycle as a missing clear pulse while `ready_o` stays high. Later it also shows as operation commands that leak out during a sequence that should be incomplete. Fourth-word fields left over from an earlier sequence show as nonzero outputs right after an opening word that requests no fourth word.

// File: rtl/icw_seq_pkg.sv
package icw_seq_pkg;

    localparam int DW        = 8;
    localparam int START_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W2,
        ST_W3,
        ST_W4,
        ST_RDY
    } seq_st_t;

    typedef struct packed {
        logic [2:0] a_hi;
        logic       level;
        logic       adi;
        logic       single;
        logic       need4;
    } w1_t;

    typedef struct packed {
        logic sfnm;
        logic bufd;
        logic ms;
        logic aeoi;
        logic pm;
    } w4_t;

    function automatic logic is_start(input logic a0, input logic [DW-1:0] d);
        return (!a0) && d[START_BIT];
    endfunction

    function automatic w1_t unpack_w1(input logic [DW-1:0] d);
        w1_t r;
        r.a_hi   = d[7:5];
        r.level  = d[3];
        r.adi    = d[2];
        r.single = d[1];
        r.need4  = d[0];
        return r;
    endfunction

    function automatic w4_t unpack_w4(input logic [DW-1:0] d);
        w4_t r;
        r.sfnm = d[4];
        r.bufd = d[3];
        r.ms   = d[2];
        r.aeoi = d[1];
        r.pm   = d[0];
        return r;
    endfunction

    function automatic seq_st_t after_w2(input w1_t c);
        if (!c.single) return ST_W3;
        if (c.need4)   return ST_W4;
        return ST_RDY;
    endfunction

    function automatic seq_st_t after_w3(input w1_t c);
        return c.need4 ? ST_W4 : ST_RDY;
    endfunction

endpackage

// File: rtl/icw_seq_fsm.sv
module icw_seq_fsm
    import icw_seq_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic         wr_a0,
    input  logic [W-1:0] wr_data,
    input  w1_t          cfg1,
    output logic         start_hit,
    output logic         ld_w2,
    output logic         ld_w3,
    output logic         ld_w4,
    output logic         ocw_hit,
    output logic         ready
);

    seq_st_t st_q, st_d;

    always_comb begin
        start_hit = wr_stb && is_start(wr_a0, wr_data);
        ld_w2     = wr_stb && !start_hit && (st_q == ST_W2);
        ld_w3     = wr_stb && !start_hit && (st_q == ST_W3);
        ld_w4     = wr_stb && !start_hit && (st_q == ST_W4);
        ocw_hit   = wr_stb && !start_hit && (st_q == ST_RDY);
        ready     = (st_q == ST_RDY);
    end

    always_comb begin
        st_d = st_q;
        if (start_hit)  st_d = ST_W2;
        else if (ld_w2) st_d = after_w2(cfg1);
        else if (ld_w3) st_d = after_w3(cfg1);
        else if (ld_w4) st_d = ST_RDY;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/icw_seq_regs.sv
module icw_seq_regs
    import icw_seq_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wr_data,
    input  logic         start_hit,
    input  logic         ld_w2,
    input  logic         ld_w3,
    input  logic         ld_w4,
    output w1_t          cfg1,
    output logic [W-1:0] vec_hi,
    output logic [W-1:0] slave,
    output w4_t          cfg4
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg1   <= '0;
            vec_hi <= '0;
            slave  <= '0;
            cfg4   <= '0;
        end else begin
            if (start_hit) begin
                cfg1  <= unpack_w1(wr_data);
                cfg4  <= '0;
                slave <= '0;
            end
            if (ld_w2) vec_hi <= wr_data;
            if (ld_w3) slave  <= wr_data;
            if (ld_w4) cfg4   <= unpack_w4(wr_data);
        end
    end

endmodule

// File: rtl/icw_seq_side.sv
module icw_seq_side
    import icw_seq_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_hit,
    input  logic         ocw_hit,
    input  logic         wr_a0,
    input  logic [W-1:0] wr_data,
    output logic         init_clr,
    output logic         ocw_valid,
    output logic         ocw_a0,
    output logic [W-1:0] ocw_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_clr  <= 1'b0;
            ocw_valid <= 1'b0;
            ocw_a0    <= 1'b0;
            ocw_data  <= '0;
        end else begin
            init_clr  <= start_hit;
            ocw_valid <= ocw_hit;
            if (ocw_hit) begin
                ocw_a0   <= wr_a0;
                ocw_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/icw_seq_top.sv
module icw_seq_top
    import icw_seq_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic         wr_a0,
    input  logic [W-1:0] wr_data,
    output logic         ready_o,
    output logic         level_trig_o,
    output logic         spacing4_o,
    output logic         single_o,
    output logic         need4_o,
    output logic [2:0]   vec_lo_o,
    output logic [W-1:0] vec_hi_o,
    output logic [W-1:0] slave_o,
    output logic         sfnm_o,
    output logic         buffered_o,
    output logic         master_o,
    output logic         aeoi_o,
    output logic         two_pulse_o,
    output logic         mask_clr_o,
    output logic         edge_rst_o,
    output logic         prio_rst_o,
    output logic         smm_clr_o,
    output logic         rd_irr_o,
    output logic         ocw_valid_o,
    output logic         ocw_a0_o,
    output logic [W-1:0] ocw_data_o
);

    w1_t  cfg1;
    w4_t  cfg4;
    logic start_hit, ld_w2, ld_w3, ld_w4, ocw_hit, init_clr;

    icw_seq_fsm #(.W(W)) fsm_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_a0(wr_a0), .wr_data(wr_data),
        .cfg1(cfg1), .start_hit(start_hit), .ld_w2(ld_w2), .ld_w3(ld_w3),
        .ld_w4(ld_w4), .ocw_hit(ocw_hit), .ready(ready_o)
    );

    icw_seq_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .wr_data(wr_data), .start_hit(start_hit),
        .ld_w2(ld_w2), .ld_w3(ld_w3), .ld_w4(ld_w4),
        .cfg1(cfg1), .vec_hi(vec_hi_o), .slave(slave_o), .cfg4(cfg4)
    );

    icw_seq_side #(.W(W)) side_i (
        .clk(clk), .rst(rst), .start_hit(start_hit), .ocw_hit(ocw_hit),
        .wr_a0(wr_a0), .wr_data(wr_data), .init_clr(init_clr),
        .ocw_valid(ocw_valid_o), .ocw_a0(ocw_a0_o), .ocw_data(ocw_data_o)
    );

    always_comb begin
        level_trig_o = cfg1.level;
        spacing4_o   = cfg1.adi;
        single_o     = cfg1.single;
        need4_o      = cfg1.need4;
        vec_lo_o     = cfg1.a_hi;
        sfnm_o       = cfg4.sfnm;
        buffered_o   = cfg4.bufd;
        master_o     = cfg4.ms;
        aeoi_o       = cfg4.aeoi;
        two_pulse_o  = cfg4.pm;
        mask_clr_o   = init_clr;
        edge_rst_o   = init_clr;
        prio_rst_o   = init_clr;
        smm_clr_o    = init_clr;
        rd_irr_o     = init_clr;
    end

endmodule

// File: rtl/icw_seq_chk.sv
module icw_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_stb,
    input logic         wr_a0,
    input logic [W-1:0] wr_data,
    input logic         ready_o,
    input logic [W-1:0] vec_hi_o,
    input logic         sfnm_o,
    input logic         buffered_o,
    input logic         master_o,
    input logic         aeoi_o,
    input logic         two_pulse_o,
    input logic         mask_clr_o,
    input logic         ocw_valid_o
);

    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_a0 && wr_data[4]) |=> (!ready_o && mask_clr_o));

    assert_ready_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(wr_stb));

    assert_vec_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !wr_stb) |=> $stable(vec_hi_o));

    assert_w4_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_a0 && wr_data[4] && !wr_data[0]) |=>
        !(sfnm_o || buffered_o || master_o || aeoi_o || two_pulse_o));

    assert_clr_cause_R8: assert property (@(posedge clk) disable iff (rst)
        mask_clr_o |-> $past(wr_stb));

    assert_ocw_ready_R9: assert property (@(posedge clk) disable iff (rst)
        ocw_valid_o |-> (ready_o && $past(ready_o)));

    assert_no_ocw_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && wr_stb) |=> !ocw_valid_o);

endmodule

bind icw_seq_top icw_seq_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_a0(wr_a0), .wr_data(wr_data),
    .ready_o(ready_o), .vec_hi_o(vec_hi_o), .sfnm_o(sfnm_o),
    .buffered_o(buffered_o), .master_o(master_o), .aeoi_o(aeoi_o),
    .two_pulse_o(two_pulse_o), .mask_clr_o(mask_clr_o), .ocw_valid_o(ocw_valid_o)
);

// File: tb/icw_seq_top_tb_top.sv
module icw_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic       wr_a0 = 1'b0;
    logic [7:0] wr_data = 8'h00;

    logic       ready_o, level_trig_o, spacing4_o, single_o, need4_o;
    logic [2:0] vec_lo_o;
    logic [7:0] vec_hi_o, slave_o, ocw_data_o;
    logic       sfnm_o, buffered_o, master_o, aeoi_o, two_pulse_o;
    logic       mask_clr_o, edge_rst_o, prio_rst_o, smm_clr_o, rd_irr_o;
    logic       ocw_valid_o, ocw_a0_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    icw_seq_top dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_a0(wr_a0), .wr_data(wr_data),
        .ready_o(ready_o), .level_trig_o(level_trig_o), .spacing4_o(spacing4_o),
        .single_o(single_o), .need4_o(need4_o), .vec_lo_o(vec_lo_o),
        .vec_hi_o(vec_hi_o), .slave_o(slave_o), .sfnm_o(sfnm_o),
        .buffered_o(buffered_o), .master_o(master_o), .aeoi_o(aeoi_o),
        .two_pulse_o(two_pulse_o), .mask_clr_o(mask_clr_o), .edge_rst_o(edge_rst_o),
        .prio_rst_o(prio_rst_o), .smm_clr_o(smm_clr_o), .rd_irr_o(rd_irr_o),
        .ocw_valid_o(ocw_valid_o), .ocw_a0_o(ocw_a0_o), .ocw_data_o(ocw_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write; returns at the negedge after the capturing edge
    task automatic wr(input logic a0, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_a0 = a0; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0; wr_a0 = 1'b0; wr_data = 8'h00;
    endtask

    function automatic logic [4:0] pulses();
        return {mask_clr_o, edge_rst_o, prio_rst_o, smm_clr_o, rd_irr_o};
    endfunction

    function automatic logic [4:0] w4f();
        return {sfnm_o, buffered_o, master_o, aeoi_o, two_pulse_o};
    endfunction

    task automatic t_reset();
        chk("R1 ready", ready_o, 0);
        chk("R1 fields", {level_trig_o, spacing4_o, single_o, need4_o, vec_lo_o, vec_hi_o, slave_o}, 0);
        chk("R1 w4", w4f(), 0);
        chk("R1 pulses", {pulses(), ocw_valid_o}, 0);
    endtask

    task automatic t_pre_init_ignored();
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'h0C);
        chk("R10 ready", ready_o, 0);
        chk("R10 no ocw", ocw_valid_o, 0);
        chk("R10 vec", vec_hi_o, 0);
    endtask

    // single, no fourth word: two bytes
    task automatic t_single_no4();
        wr(1'b0, 8'b101_1_1_1_1_0);
        chk("R8 pulses", pulses(), 5'b11111);
        chk("R2 ready low", ready_o, 0);
        chk("R4 fields", {vec_lo_o, level_trig_o, spacing4_o, single_o, need4_o}, 7'b101_1_1_1_0);
        @(negedge clk);
        chk("R8 one cycle", pulses(), 0);
        wr(1'b1, 8'hC3);
        chk("R3 ready after 2", ready_o, 1);
        chk("R5 vec_hi", vec_hi_o, 8'hC3);
        chk("R7 w4 zero", w4f(), 0);
        repeat (3) @(negedge clk);
        chk("R5 stable", vec_hi_o, 8'hC3);
    endtask

    // cascade plus fourth word: four bytes
    task automatic t_cascade_with4();
        wr(1'b0, 8'b010_1_0_0_0_1);
        chk("R4 fields", {vec_lo_o, level_trig_o, spacing4_o, single_o, need4_o}, 7'b010_0_0_0_1);
        wr(1'b1, 8'h3C);
        chk("R3 not ready after 2", ready_o, 0);
        wr(1'b1, 8'h84);
        chk("R3 not ready after 3", ready_o, 0);
        chk("R6 slave", slave_o, 8'h84);
        chk("R10 no ocw in seq", ocw_valid_o, 0);
        wr(1'b1, 8'b000_10101);
        chk("R3 ready after 4", ready_o, 1);
        chk("R7 w4 fields", w4f(), 5'b10101);
        chk("R5 vec_hi", vec_hi_o, 8'h3C);
    endtask

    // single plus fourth word: three bytes, third skipped
    task automatic t_single_with4();
        wr(1'b0, 8'b000_1_0_0_1_1);
        chk("R7 cleared at start", w4f(), 0);
        wr(1'b1, 8'h11);
        chk("R3 wait w4", ready_o, 0);
        wr(1'b1, 8'b000_01010);
        chk("R3 ready after 3", ready_o, 1);
        chk("R7 w4 fields", w4f(), 5'b01010);
        chk("R6 slave untouched", slave_o, 8'h00);
    endtask

    // cascade, no fourth word: three bytes, w4 stays zero
    task automatic t_cascade_no4();
        wr(1'b0, 8'b111_1_1_0_0_0);
        wr(1'b1, 8'hE0);
        wr(1'b1, 8'h07);
        chk("R3 ready after 3", ready_o, 1);
        chk("R6 slave", slave_o, 8'h07);
        chk("R7 w4 zero", w4f(), 0);
    endtask

    task automatic t_ocw_pass();
        wr(1'b1, 8'hA5);
        chk("R9 valid", ocw_valid_o, 1);
        chk("R9 payload", {ocw_a0_o, ocw_data_o}, 9'h1A5);
        chk("R9 fields kept", {vec_hi_o, slave_o}, 16'hE007);
        @(negedge clk);
        chk("R9 one cycle", ocw_valid_o, 0);
        wr(1'b0, 8'h08);
        chk("R9 a0 low", {ocw_valid_o, ocw_a0_o, ocw_data_o}, 10'b1_0_00001000);
        chk("R9 still ready", ready_o, 1);
    endtask

    task automatic t_restart_mid();
        wr(1'b0, 8'b000_1_0_0_0_1);
        wr(1'b1, 8'h22);
        wr(1'b0, 8'b110_1_0_1_1_0);
        chk("R2 restart pulses", pulses(), 5'b11111);
        chk("R2 ready low", ready_o, 0);
        chk("R4 new fields", {vec_lo_o, spacing4_o, single_o, need4_o}, 6'b110_1_1_0);
        wr(1'b1, 8'h99);
        chk("R2 restarted seq ready", ready_o, 1);
        chk("R5 vec_hi", vec_hi_o, 8'h99);
        wr(1'b0, 8'h10);
        chk("R2 restart from ready", ready_o, 0);
        chk("R10 no ocw on start", ocw_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pre_init_ignored();
        t_single_no4();
        t_cascade_with4();
        t_single_with4();
        t_cascade_no4();
        t_ocw_pass();
        t_restart_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule